// File: doc/BRIEF.md
# Read-Path Byte-Lane Parity Checker

This block watches a 64-bit read data bus with one even-parity bit per byte lane and judges every completed read transfer. A read is complete at the rising clock edge where the active-low ready strobe is low and the direction input says "read". At that edge each lane's eight data bits and its parity bit are folded together. A lane whose total count of ones is odd is bad, but it only counts when its active-low byte enable selects it.

When at least one selected lane is bad and the active-low check enable is asserted, the block pulls its active-low error line low for the one clock cycle after the sampling edge. A registered per-lane error vector keeps the lanes that failed in the latest completed read, for debug. It holds that value until the next completed read. The vector is updated whether or not checking is enabled.

Reporting is handled by a two-state machine. State `ST_QUIET` holds the error line high and `ST_FLAG` holds it low. Transition `QUIET->FLAG` is taken on a completed, enabled read with a bad selected lane. `FLAG->FLAG` is taken when the next cycle is another such read. `FLAG->QUIET` is taken on any other cycle. `QUIET->QUIET` is taken otherwise. Synchronous reset forces `ST_QUIET`.

Top module: `par_chk_top`

## Requirements
- R1: Lane i covers data bits [8i+7:8i] and parity bit i. A lane is bad when the XOR of its eight data bits and its parity bit is 1, which means the nine bits hold an odd count of ones.
- R2: Byte enable bit i is active low and selects lane i. Lane 0 is the least significant byte. A lane whose enable bit is 1 never shows up in the error vector and never causes an error report.
- R3: A completed read is a rising edge with `rdy_n`=0 and `wr_nrd`=0. If any selected lane is bad and `chk_en_n`=0 at that edge, `perr_n` is 0 during the following clock cycle.
- R4: A cycle with `wr_nrd`=1 never drives `perr_n` low and leaves `lane_err` unchanged.
- R5: While `chk_en_n`=1 at the sampling edge, `perr_n` stays 1. `lane_err` is still updated.
- R6: `lane_err` bit i is 1 after a completed read exactly when lane i was selected and bad. The vector holds its value until the next completed read.
- R7: A cycle with `rdy_n`=1 samples nothing. `perr_n` is 1 in the cycle after it and `lane_err` is held, so one erroring read gives a low pulse of exactly one cycle.
- R8: Synchronous active-high reset sets `perr_n` to 1 and `lane_err` to 0.
- R9: Back-to-back erroring reads keep `perr_n` low in both following cycles. A clean read right after an erroring one returns `perr_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_data | input | 64 | Read data bus, eight byte lanes |
| rd_par | input | 8 | Even-parity bit per lane |
| lane_en_n | input | 8 | Byte enables, active low |
| chk_en_n | input | 1 | Parity check enable, active low |
| rdy_n | input | 1 | Ready strobe marking the data phase, active low |
| wr_nrd | input | 1 | Cycle direction, 1 = write, 0 = read |
| perr_n | output | 1 | Parity error report, active low |
| lane_err | output | 8 | Lanes that failed in the latest completed read |

## Verification
The bench runs through every lane with good and flipped parity, both selected and deselected. It then applies all 256 byte-enable patterns with varied bad-lane masks.
- A design that swapped lane order or computed odd parity would mark the wrong vector bits.
- One that ignored the enables would flag deselected lanes.
- Writes, idle cycles and a negated check enable follow an erroring read. A design that sampled without the ready strobe or on writes, or that stretched the pulse, would leave `perr_n` low or disturb the held vector.
- Back-to-back erroring and clean reads, plus a reset right after an error, catch a machine that drops a repeated report or fails to clear.

// File: rtl/par_chk_pkg.sv
package par_chk_pkg;
    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_FLAG  = 1'b1
    } chk_state_t;
endpackage

// File: rtl/par_lane_xor.sv
module par_lane_xor #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] bits,
    input  logic              par,
    input  logic              sel_n,
    output logic              bad
);
    logic odd_ones;

    // Even parity: data plus parity must hold an even number of ones
    always_comb begin
        odd_ones = ^{bits, par};
        bad      = odd_ones & ~sel_n;
    end
endmodule

// File: rtl/par_chk_fsm.sv
module par_chk_fsm
    import par_chk_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             act,
    input  logic [LANES-1:0] lane_bad,
    output logic             perr_n,
    output logic [LANES-1:0] lane_err
);
    chk_state_t state, state_nx;
    logic       hit;

    always_comb begin
        hit      = sample & act & (|lane_bad);
        state_nx = state;
        unique case (state)
            ST_QUIET: state_nx = hit ? ST_FLAG : ST_QUIET;
            ST_FLAG:  state_nx = hit ? ST_FLAG : ST_QUIET;
            default:  state_nx = ST_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_QUIET;
        else     state <= state_nx;
    end

    // Outputs: registered lane vector, state-decoded error line
    always_ff @(posedge clk) begin
        if (rst)         lane_err <= '0;
        else if (sample) lane_err <= lane_bad;
    end

    always_comb perr_n = (state != ST_FLAG);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (perr_n && lane_err == '0));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(lane_err));

    assert_flag_needs_vector_R3: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> (lane_err != '0));

    assert_silent_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        !act |=> perr_n);
endmodule

// File: rtl/par_chk_top.sv
module par_chk_top #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*LANE_W-1:0] rd_data,
    input  logic [LANES-1:0]        rd_par,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    chk_en_n,
    input  logic                    rdy_n,
    input  logic                    wr_nrd,
    output logic                    perr_n,
    output logic [LANES-1:0]        lane_err
);
    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0] lane_bad;
    logic             sample;
    logic             act;

    always_comb begin
        sample = ~rdy_n & ~wr_nrd;
        act    = ~chk_en_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        par_lane_xor #(.LANE_W(LANE_W)) u_lane (
            .bits  (rd_data[g*LANE_W +: LANE_W]),
            .par   (rd_par[g]),
            .sel_n (lane_en_n[g]),
            .bad   (lane_bad[g])
        );
    end

    par_chk_fsm #(.LANES(LANES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .act      (act),
        .lane_bad (lane_bad),
        .perr_n   (perr_n),
        .lane_err (lane_err)
    );

    assert_masked_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        sample |=> ((lane_err & $past(lane_en_n)) == '0));

    assert_no_flag_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_nrd && !rst) |=> (perr_n && $stable(lane_err)));

    assert_flag_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (!sample || rdy_n) |=> perr_n);

    initial begin
        assert (DATA_W == LANES * LANE_W) else $error("width mismatch");
    end
endmodule

// File: tb/sim_par_chk_top.sv
module sim_par_chk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_par = '0;
    logic [7:0]  lane_en_n = 8'hFF;
    logic        chk_en_n = 1'b1;
    logic        rdy_n = 1'b1;
    logic        wr_nrd = 1'b0;
    logic        perr_n;
    logic [7:0]  lane_err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_err = '0;
    logic       m_perr = 1'b1;

    always #4 clk = ~clk;

    par_chk_top u0 (
        .clk(clk), .rst(rst), .rd_data(rd_data), .rd_par(rd_par),
        .lane_en_n(lane_en_n), .chk_en_n(chk_en_n), .rdy_n(rdy_n),
        .wr_nrd(wr_nrd), .perr_n(perr_n), .lane_err(lane_err)
    );

    function automatic logic [7:0] even_bits(input logic [63:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ^d[8*i +: 8];
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic [63:0] d, input logic [7:0] p, input logic [7:0] en,
                        input logic chk, input logic wr, input logic rdy, input string req);
        @(negedge clk);
        rd_data = d; rd_par = p; lane_en_n = en; chk_en_n = chk; wr_nrd = wr; rdy_n = rdy;
        if (!rdy && !wr) begin
            m_err  = (p ^ even_bits(d)) & ~en;
            m_perr = !(!chk && (m_err != 8'h00));
        end else begin
            m_perr = 1'b1;
        end
        @(posedge clk); #2;
        check(perr_n == m_perr, {req, " perr_n"}, {7'd0, perr_n}, {7'd0, m_perr});
        check(lane_err == m_err, {req, " lane_err"}, lane_err, m_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  gp;
        repeat (2) @(posedge clk);
        #2;
        check(perr_n == 1'b1, "R8 reset perr_n", {7'd0, perr_n}, 8'h01);
        check(lane_err == 8'h00, "R8 reset lane_err", lane_err, 8'h00);
        @(negedge clk); rst = 1'b0;

        // R1 / R2: single-lane sweep, parity good or flipped, lane selected or not
        for (int lane = 0; lane < 8; lane++) begin
            for (int mode = 0; mode < 4; mode++) begin
                d  = 64'h0123_4567_89AB_CDEF ^ (64'hA5 << (8 * lane));
                gp = even_bits(d) ^ ((mode[0]) ? (8'h01 << lane) : 8'h00);
                xfer(d, gp, (mode[1]) ? 8'hFF : ~(8'h01 << lane), 1'b0, 1'b0, 1'b0, "R1_R2 lane sweep");
                xfer(d, gp, 8'h00, 1'b0, 1'b0, 1'b1, "R7 idle after read");
            end
        end

        // R2 / R6: every byte-enable pattern with varied bad-lane masks
        d = 64'h0;
        for (int en = 0; en < 256; en++) begin
            d  = d * 64'd6364136223846793005 + 64'd1442695040888963407;
            gp = even_bits(d) ^ 8'(en * 37 + 11);
            xfer(d, gp, 8'(en), 1'b0, 1'b0, 1'b0, "R2_R6 enable sweep");
        end

        // R3 / R7: one erroring read then idle gives exactly one low cycle
        d = 64'hFFFF_0000_1234_5678;
        xfer(d, even_bits(d) ^ 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, "R3 error report");
        xfer(d, even_bits(d) ^ 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, "R7 ready high ignored");
        // R4: write with bad parity after an error
        xfer(d, even_bits(d) ^ 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, "R3 error report again");
        xfer(d, even_bits(d) ^ 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0, "R4 write ignored");
        // R5: checking disabled still updates vector
        xfer(d, even_bits(d) ^ 8'h3C, 8'h00, 1'b1, 1'b0, 1'b0, "R5 check disabled");
        xfer(d, even_bits(d) ^ 8'h3C, 8'h00, 1'b1, 1'b0, 1'b1, "R5 hold after disabled");
        // R9: back-to-back errors, then clean read
        xfer(d, even_bits(d) ^ 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, "R9 first of pair");
        xfer(d, even_bits(d) ^ 8'h02, 8'h00, 1'b0, 1'b0, 1'b0, "R9 second of pair");
        xfer(d, even_bits(d), 8'h00, 1'b0, 1'b0, 1'b0, "R9 clean read clears");
        // R8: reset right after an error
        xfer(d, even_bits(d) ^ 8'h44, 8'h00, 1'b0, 1'b0, 1'b0, "R8 error before reset");
        @(negedge clk); rst = 1'b1; rdy_n = 1'b1;
        @(posedge clk); #2;
        m_err = 8'h00; m_perr = 1'b1;
        check(perr_n == 1'b1, "R8 mid-run reset perr_n", {7'd0, perr_n}, 8'h01);
        check(lane_err == 8'h00, "R8 mid-run reset lane_err", lane_err, 8'h00);
        @(negedge clk); rst = 1'b0;
        xfer(d, even_bits(d) ^ 8'h10, 8'hEF, 1'b0, 1'b0, 1'b0, "R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule